// File: doc/BRIEF.md
# Code-Density Linearity Calibrator for a Time-to-Digital Converter

This block straightens the transfer curve of a delay-line time-to-digital converter without a ramp or reference source. While calibration runs, the converter is fed by two free-running oscillators that have different frequencies and no lock between them. Because of that stimulus, a perfectly uniform converter would land in every code equally often. The calibrator clears a code-occupancy histogram and then gathers a programmable number of samples, 2^K. Each bin count stands for the width of its code. A running sum over the bins in ascending code order gives the cumulative (integral) error curve. The calibrator inverts that curve into a correction table that maps each raw code to a linear output code.

In run mode each raw code that arrives with its valid flag is replaced by its table entry one cycle later. The correction only removes relative mismatch among the delay stages. Setting the absolute stage delay is left to other circuitry. The table is written entirely by digital logic after the histogram is complete, and run-mode results are suppressed until one calibration has finished.

Top module: `tdc_lin_cal`

## Requirements
- R1: After reset, `done` and `out_valid` are low.
- R2: A start pulse taken in calibration mode clears every histogram bin. Clearing occupies the 2^CODE_W cycles after the start edge, and samples presented during that time are not counted, so a new calibration never sees counts from an earlier one.
- R3: Exactly 2^`log2n` samples are counted, with `log2n` captured at start. Samples that arrive after the last counted one, or with `raw_valid` low, have no effect on the table.
- R4: For raw code i, the table entry is min(floor(C(i)·2^CODE_W / 2^K), 2^CODE_W−1). C(i) is the sum of the bin counts of all codes below i, so C(0)=0. A uniform histogram therefore gives the identity table, and codes above the last occupied bin read the top code.
- R5: A bin counter that reaches 2^CNT_W−1 holds that value instead of wrapping.
- R6: `done` falls in the cycle after a calibration start. It rises only after the entry for the highest code has been written, and it stays high until the next calibration start.
- R7: Before the first calibration has finished, run-mode inputs give no `out_valid`.
- R8: In run mode with `done` high, `out_valid` and `out_code` appear exactly one cycle after `raw_valid`. `out_valid` is low in any cycle that follows a cycle without `raw_valid`.
- R9: Raw codes presented in calibration mode never raise `out_valid`. Raw codes presented in run mode are not counted into the histogram.
- R10: Samples of the same code on back-to-back cycles are each counted once.
- R11: A start pulse while `mode_cal` is low is ignored: `done` stays high and the table is unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_cal | input | 1 | 1 = calibration (histogram) mode, 0 = run (correction) mode |
| start | input | 1 | One-cycle pulse that begins a calibration when `mode_cal` is 1 |
| log2n | input | LOGN_W | Sample total exponent K, captured at start |
| raw_valid | input | 1 | Raw code qualifier |
| raw_code | input | CODE_W | Raw converter code |
| done | output | 1 | Correction table is complete and valid |
| out_valid | output | 1 | Corrected code qualifier, one cycle after `raw_valid` |
| out_code | output | CODE_W | Corrected code |

## Verification
The histogram update is a read-modify-write. So the read of a new sample and the write-back of the previous sample fall in the same cycle, and when both carry the same code the new read would see a stale count. The bench provokes this with runs of four identical codes sent on consecutive cycles, and with a saturation run of 1024 back-to-back samples of one code. It judges the outcome only through the finished table, read back in run mode and compared with a table the bench computes from its own saturating bin counts.

// File: rtl/tdc_cal_pkg.sv
package tdc_cal_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CLEAR,
    ST_COLLECT,
    ST_DRAIN,
    ST_ACCUM,
    ST_LAST,
    ST_DONE
  } cal_state_t;

endpackage

// File: rtl/tdc_sdp_ram.sv
// Simple dual-port memory: one write port, one registered read port,
// read-first on an address collision.
module tdc_sdp_ram #(
  parameter int DW = 8,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/tdc_code_scale.sv
// Scales a cumulative count to the output code range: cum * 2^CODE_W / 2^K,
// clamped to the top code.
module tdc_code_scale #(
  parameter int CODE_W = 4,
  parameter int SUM_W  = 12,
  parameter int LOGN_W = 4
) (
  input  logic [SUM_W-1:0]  cum,
  input  logic [LOGN_W-1:0] log2n,
  output logic [CODE_W-1:0] code
);
  localparam int WIDE_W = SUM_W + CODE_W;

  logic [WIDE_W-1:0] wide;

  always_comb begin
    wide = {cum, {CODE_W{1'b0}}} >> log2n;
    if (|wide[WIDE_W-1:CODE_W]) code = {CODE_W{1'b1}};
    else                        code = wide[CODE_W-1:0];
  end

endmodule

// File: rtl/tdc_cal_ctrl.sv
module tdc_cal_ctrl
  import tdc_cal_pkg::*;
#(
  parameter int CODE_W = 4,
  parameter int CNT_W  = 8,
  parameter int LOGN_W = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start_cal,
  input  logic                sample_valid,
  input  logic [CODE_W-1:0]   sample_code,
  input  logic [LOGN_W-1:0]   log2n,
  output logic                hist_we,
  output logic [CODE_W-1:0]   hist_waddr,
  output logic [CNT_W-1:0]    hist_wdata,
  output logic [CODE_W-1:0]   hist_raddr,
  input  logic [CNT_W-1:0]    hist_rdata,
  output logic                tbl_we,
  output logic [CODE_W-1:0]   tbl_waddr,
  output logic [CODE_W-1:0]   tbl_wdata,
  output logic                done
);
  localparam int SUM_W = CNT_W + CODE_W;
  localparam int TOT_W = (1 << LOGN_W) + 1;

  cal_state_t          state;
  logic [CODE_W-1:0]   idx;
  logic [TOT_W-1:0]    smp_cnt;
  logic [TOT_W-1:0]    total;
  logic [LOGN_W-1:0]   log2n_q;

  // collect pipeline: read in stage 0, update and write in stage 1
  logic                s1_v;
  logic [CODE_W-1:0]   s1_addr;
  logic                fw_v;
  logic [CODE_W-1:0]   fw_addr;
  logic [CNT_W-1:0]    fw_data;
  logic [CNT_W-1:0]    old_cnt;
  logic [CNT_W-1:0]    inc_cnt;

  // accumulate pipeline
  logic                a_v;
  logic [CODE_W-1:0]   a_idx;
  logic [SUM_W-1:0]    run_sum;

  logic                accept;
  logic                last_acc;
  logic                idx_top;

  assign total    = TOT_W'(1) << log2n_q;
  assign accept   = sample_valid && (state == ST_COLLECT);
  assign last_acc = accept && (smp_cnt == total - TOT_W'(1));
  assign idx_top  = (idx == {CODE_W{1'b1}});

  // the write committed at the last edge is not yet visible to the read
  // captured at that same edge: forward it
  always_comb begin
    old_cnt = (fw_v && (fw_addr == s1_addr)) ? fw_data : hist_rdata;
    inc_cnt = (&old_cnt) ? old_cnt : old_cnt + CNT_W'(1);
  end

  always_comb begin
    hist_we    = 1'b0;
    hist_waddr = s1_addr;
    hist_wdata = inc_cnt;
    if (state == ST_CLEAR) begin
      hist_we    = 1'b1;
      hist_waddr = idx;
      hist_wdata = '0;
    end else if (s1_v) begin
      hist_we = 1'b1;
    end
    hist_raddr = (state == ST_ACCUM) ? idx : sample_code;
  end

  assign tbl_we    = a_v;
  assign tbl_waddr = a_idx;

  tdc_code_scale #(
    .CODE_W (CODE_W),
    .SUM_W  (SUM_W),
    .LOGN_W (LOGN_W)
  ) u_scale (
    .cum   (run_sum),
    .log2n (log2n_q),
    .code  (tbl_wdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      idx     <= '0;
      smp_cnt <= '0;
      log2n_q <= '0;
      s1_v    <= 1'b0;
      s1_addr <= '0;
      fw_v    <= 1'b0;
      fw_addr <= '0;
      fw_data <= '0;
      a_v     <= 1'b0;
      a_idx   <= '0;
      run_sum <= '0;
      done    <= 1'b0;
    end else if (start_cal) begin
      state   <= ST_CLEAR;
      idx     <= '0;
      smp_cnt <= '0;
      log2n_q <= log2n;
      s1_v    <= 1'b0;
      fw_v    <= 1'b0;
      a_v     <= 1'b0;
      run_sum <= '0;
      done    <= 1'b0;
    end else begin
      s1_v    <= accept;
      s1_addr <= sample_code;
      fw_v    <= s1_v;
      fw_addr <= s1_addr;
      fw_data <= inc_cnt;
      a_v     <= (state == ST_ACCUM);
      a_idx   <= idx;
      if (a_v) run_sum <= run_sum + SUM_W'(hist_rdata);
      case (state)
        ST_CLEAR: begin
          idx <= idx + CODE_W'(1);
          if (idx_top) state <= ST_COLLECT;
        end
        ST_COLLECT: begin
          if (accept) smp_cnt <= smp_cnt + TOT_W'(1);
          if (last_acc) state <= ST_DRAIN;
        end
        ST_DRAIN: begin
          idx   <= '0;
          state <= ST_ACCUM;
        end
        ST_ACCUM: begin
          idx <= idx + CODE_W'(1);
          if (idx_top) state <= ST_LAST;
        end
        ST_LAST: begin
          state <= ST_DONE;
          done  <= 1'b1;
        end
        default: ;
      endcase
    end
  end

  // R5: a saturating increment never writes a wrapped zero
  p_hist_no_wrap_r5: assert property (@(posedge clk) disable iff (rst)
    (s1_v && hist_we && (hist_waddr == s1_addr)) |-> (hist_wdata != '0));

  // R3: never more samples than the programmed total
  p_sample_limit_r3: assert property (@(posedge clk) disable iff (rst)
    smp_cnt <= total);

  // R6: done rises only once the top table entry has been written
  p_done_after_write_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> $past(tbl_we && (tbl_waddr == {CODE_W{1'b1}})));

  // R6: a calibration start drops done
  p_start_clears_done_r6: assert property (@(posedge clk) disable iff (rst)
    start_cal |=> !done);

endmodule

// File: rtl/tdc_lin_cal.sv
module tdc_lin_cal #(
  parameter int CODE_W = 4,
  parameter int CNT_W  = 8,
  parameter int LOGN_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode_cal,
  input  logic              start,
  input  logic [LOGN_W-1:0] log2n,
  input  logic              raw_valid,
  input  logic [CODE_W-1:0] raw_code,
  output logic              done,
  output logic              out_valid,
  output logic [CODE_W-1:0] out_code
);
  logic              start_cal;
  logic              sample_valid;
  logic              lookup;

  logic              hist_we;
  logic [CODE_W-1:0] hist_waddr;
  logic [CNT_W-1:0]  hist_wdata;
  logic [CODE_W-1:0] hist_raddr;
  logic [CNT_W-1:0]  hist_rdata;

  logic              tbl_we;
  logic [CODE_W-1:0] tbl_waddr;
  logic [CODE_W-1:0] tbl_wdata;

  assign start_cal    = start && mode_cal;
  assign sample_valid = raw_valid && mode_cal;
  assign lookup       = raw_valid && !mode_cal && done;

  tdc_cal_ctrl #(
    .CODE_W (CODE_W),
    .CNT_W  (CNT_W),
    .LOGN_W (LOGN_W)
  ) u_ctrl (
    .clk          (clk),
    .rst          (rst),
    .start_cal    (start_cal),
    .sample_valid (sample_valid),
    .sample_code  (raw_code),
    .log2n        (log2n),
    .hist_we      (hist_we),
    .hist_waddr   (hist_waddr),
    .hist_wdata   (hist_wdata),
    .hist_raddr   (hist_raddr),
    .hist_rdata   (hist_rdata),
    .tbl_we       (tbl_we),
    .tbl_waddr    (tbl_waddr),
    .tbl_wdata    (tbl_wdata),
    .done         (done)
  );

  tdc_sdp_ram #(.DW(CNT_W), .AW(CODE_W)) u_hist (
    .clk   (clk),
    .we    (hist_we),
    .waddr (hist_waddr),
    .wdata (hist_wdata),
    .raddr (hist_raddr),
    .rdata (hist_rdata)
  );

  tdc_sdp_ram #(.DW(CODE_W), .AW(CODE_W)) u_tbl (
    .clk   (clk),
    .we    (tbl_we),
    .waddr (tbl_waddr),
    .wdata (tbl_wdata),
    .raddr (raw_code),
    .rdata (out_code)
  );

  always_ff @(posedge clk) begin
    if (rst) out_valid <= 1'b0;
    else     out_valid <= lookup;
  end

  // R8: a valid run-mode lookup answers in the next cycle
  p_lookup_latency_r8: assert property (@(posedge clk) disable iff (rst)
    (raw_valid && !mode_cal && done) |=> out_valid);

  // R7: no result without a finished table
  p_no_out_before_cal_r7: assert property (@(posedge clk) disable iff (rst)
    !done |=> !out_valid);

  // R9: calibration samples stay silent at the output
  p_cal_samples_silent_r9: assert property (@(posedge clk) disable iff (rst)
    (raw_valid && mode_cal) |=> !out_valid);

  // R11: start in run mode leaves a finished table in place
  p_start_ignored_run_r11: assert property (@(posedge clk) disable iff (rst)
    (start && !mode_cal && done) |=> done);

endmodule

// File: tb/sim_tdc_lin_cal.sv
module sim_tdc_lin_cal;
  localparam int CODE_W = 4;
  localparam int CNT_W  = 8;
  localparam int LOGN_W = 4;
  localparam int M      = 1 << CODE_W;
  localparam int CMAX   = (1 << CNT_W) - 1;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              mode_cal = 1'b0;
  logic              start = 1'b0;
  logic [LOGN_W-1:0] log2n = '0;
  logic              raw_valid = 1'b0;
  logic [CODE_W-1:0] raw_code = '0;
  logic              done;
  logic              out_valid;
  logic [CODE_W-1:0] out_code;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;
  int seq [0:2047];
  int exp_tbl [0:M-1];

  always #2 clk = ~clk;

  tdc_lin_cal #(.CODE_W(CODE_W), .CNT_W(CNT_W), .LOGN_W(LOGN_W)) u0 (
    .clk (clk), .rst (rst), .mode_cal (mode_cal), .start (start),
    .log2n (log2n), .raw_valid (raw_valid), .raw_code (raw_code),
    .done (done), .out_valid (out_valid), .out_code (out_code)
  );

  task automatic check(string req, int act, int expv);
    n_chk++;
    if (act != expv) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  // expected table from the first 2^k entries of seq, saturating bins
  task automatic build_model(int k);
    int hist [0:M-1];
    int cum;
    int v;
    for (int i = 0; i < M; i++) hist[i] = 0;
    for (int j = 0; j < (1 << k); j++)
      if (hist[seq[j]] < CMAX) hist[seq[j]]++;
    cum = 0;
    for (int i = 0; i < M; i++) begin
      v = (cum * M) >> k;
      exp_tbl[i] = (v > M - 1) ? M - 1 : v;
      cum += hist[i];
    end
  endtask

  task automatic start_cal(int k);
    @(negedge clk);
    mode_cal = 1'b1; log2n = LOGN_W'(k); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R6 done low after start", int'(done), 0);
    // junk during the clear window must not be counted (R2)
    for (int j = 0; j < M - 2; j++) begin
      raw_valid = 1'b1; raw_code = CODE_W'(M - 1);
      @(negedge clk);
    end
    raw_valid = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic feed(int n, string tag);
    for (int j = 0; j < n; j++) begin
      raw_valid = 1'b1; raw_code = CODE_W'(seq[j]);
      @(negedge clk);
      if (j % 64 == 0) check({tag, " R9 no out_valid in cal mode"}, int'(out_valid), 0);
    end
    raw_valid = 1'b0;
  endtask

  task automatic wait_done(string tag);
    int c;
    check({tag, " R6 done not yet high"}, int'(done), 0);
    c = 0;
    while (!done && c < 2000) begin
      @(negedge clk);
      c++;
    end
    check({tag, " R6 done reached"}, int'(done), 1);
  endtask

  task automatic verify_table(string tag);
    @(negedge clk);
    mode_cal = 1'b0;
    for (int i = 0; i < M; i++) begin
      raw_valid = 1'b1; raw_code = CODE_W'(i);
      @(negedge clk);
      check({tag, " R8 out_valid one cycle later"}, int'(out_valid), 1);
      check({tag, " R4 table entry"}, int'(out_code), exp_tbl[i]);
    end
    raw_valid = 1'b0;
    @(negedge clk);
    check({tag, " R8 out_valid low without raw_valid"}, int'(out_valid), 0);
  endtask

  task automatic t_reset;
    check("R1 done after reset", int'(done), 0);
    check("R1 out_valid after reset", int'(out_valid), 0);
  endtask

  task automatic t_precal;
    mode_cal = 1'b0;
    for (int j = 0; j < 3; j++) begin
      raw_valid = 1'b1; raw_code = CODE_W'(j);
      @(negedge clk);
      check("R7 no output before calibration", int'(out_valid), 0);
    end
    raw_valid = 1'b0;
  endtask

  // uniform stimulus plus 8 extra samples past the total (R3)
  task automatic t_uniform;
    for (int j = 0; j < 264; j++) seq[j] = j % M;
    build_model(8);
    for (int i = 0; i < M; i++) check("R4 uniform model is identity", exp_tbl[i], i);
    start_cal(8);
    feed(264, "uniform");
    wait_done("uniform");
    verify_table("uniform R3");
  endtask

  // runs of four equal codes back to back, empty upper bins (R10, R2, R4 clamp)
  task automatic t_runs;
    for (int j = 0; j < 256; j++) seq[j] = ((j >> 2) * (j >> 2)) % M;
    build_model(8);
    start_cal(8);
    feed(256, "runs R10");
    wait_done("runs");
    verify_table("runs R10 R2");
  endtask

  // one code hammered past the counter limit (R5)
  task automatic t_sat;
    for (int j = 0; j < 1024; j++) seq[j] = 3;
    build_model(10);
    start_cal(10);
    feed(1024, "sat R5");
    wait_done("sat");
    verify_table("sat R5");
  endtask

  // start in run mode is ignored, run-mode samples are not counted (R11, R9)
  task automatic t_start_in_run;
    @(negedge clk);
    mode_cal = 1'b0; start = 1'b1; raw_valid = 1'b1; raw_code = '0;
    @(negedge clk);
    start = 1'b0; raw_valid = 1'b0;
    repeat (M + 4) @(negedge clk);
    check("R11 done kept", int'(done), 1);
    verify_table("R11 table kept");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_precal();
    t_uniform();
    t_runs();
    t_sat();
    t_start_in_run();
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule